// File: doc/BRIEF.md
# Programmable Memory Pattern Sequencer

This block is a small microcoded engine that produces external-memory control timing. Software fills an internal pattern store through a write port. Each stored word gives one clock cycle of behaviour: whether the selected bank's chip select is asserted, a four-bit group of control-line levels, an end-of-pattern flag and a flag that arms a per-bank recovery timer. A requester presents a bank number and a start index. The sequencer then plays the words from that index, one per cycle, until it reaches a word marked as the end.

Each bank has its own recovery counter. When the final word of a pattern arms the counter, a later pattern on the same bank cannot start until the counter runs down. This gives a guaranteed gap, for example a DRAM precharge time. If the next request targets that same bank, the sequencer keeps driving the final word's values for the whole gap instead of going quiet. Requests to other banks are not slowed by this. An ownership map says which banks this sequencer may drive. A bank that is not owned has its chip select left alone, while the control lines still follow the pattern.

A requester holds its request stable until it sees `done`, and it may present the next request from the cycle that follows.

Top module: `mem_pattern_seq`

## Requirements
- R1: During and straight after reset, all `cs_n` lines are high, `ctl` is 0 and `done` is 0.
- R2: A request accepted while idle, to a bank whose timer is free, shows the word at `req_start` in the next cycle. Later words come from consecutive addresses, one per cycle, and the address wraps from 63 to 0.
- R3: In a pattern cycle, `cs_n[b]` is low only when the word's chip-select bit (bit 2, 1 = assert) is set and `b` is the requested bank. All other chip selects are high.
- R4: A bank whose `own_map` bit is 0 never has its chip select driven low. `ctl` still follows the pattern words (bits 6:3).
- R5: `done` is high for exactly the cycle that shows the word with the end bit set (bit 0). After that, the outputs are idle (`cs_n` all high, `ctl` 0) unless R6 applies.
- R6: If the end word also has the timer bit set (bit 1) and `dis_period` = P ≥ 1, then for a next request to the same bank the final word's `ctl` and chip-select values repeat for P cycles. The next pattern's first word appears P+1 cycles after the end word.
- R7: A timer bit in a word without the end bit has no effect on when the next pattern starts.
- R8: A running timer on one bank does not delay a request to a different bank.
- R9: With `dis_period` = 0, an armed end word causes no hold. A same-bank request is served as if it came from idle.
- R10: A request to a bank whose timer is still running, when that bank is not the one just finished, waits with idle outputs. It is accepted in the cycle in which the timer reaches 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, held until `done` |
| req_bank | input | 3 | Bank of the request |
| req_start | input | 6 | Index of the first pattern word |
| own_map | input | 8 | Per bank: 1 = this sequencer drives its chip select |
| dis_period | input | 8 | Recovery timer period in cycles |
| wr_en | input | 1 | Pattern store write strobe |
| wr_addr | input | 6 | Pattern store write index |
| wr_data | input | 7 | Pattern word {ctl[3:0], cs, timer, end} |
| cs_n | output | 8 | Active-low chip selects |
| ctl | output | 4 | Control-line levels of the current word |
| done | output | 1 | One-cycle pulse on the final pattern word |

## Verification
The hardest situation to reach is a request that waits on a bank timer armed two patterns earlier. By then the hold record belongs to a different bank, so the outputs must stay idle rather than be extended. The stimulus arms bank 3 with a ten-cycle period and runs a one-word pattern on bank 4 at once. It then asks for bank 3 again and measures the spacing of the `done` pulses, while a cycle-level model compares every output on every clock. The same-bank hold, the zero period, the ignored mid-pattern timer bit and the address wrap are each reached with short directed pattern pairs.

// File: rtl/mps_pkg.sv
package mps_pkg;

  localparam int CTL_W = 4;

  typedef struct packed {
    logic [CTL_W-1:0] ctl;
    logic             cs_on;
    logic             tmr_on;
    logic             last;
  } pat_word_t;

  localparam int WORD_W = $bits(pat_word_t);

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/mps_pattern_ram.sv
module mps_pattern_ram #(
  parameter int DEPTH  = 64,
  parameter int WIDTH  = 7,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    rd_data = mem_q[rd_addr];
  end

endmodule

// File: rtl/mps_bank_timers.sv
module mps_bank_timers #(
  parameter int NUM_BANKS = 8,
  parameter int TMR_W     = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic [BANK_W-1:0]    load_bank,
  input  logic [TMR_W-1:0]     period,
  output logic [NUM_BANKS-1:0] free
);

  logic [TMR_W-1:0] cnt_q [NUM_BANKS];
  logic [TMR_W-1:0] cnt_d [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic load_here;

    always_comb begin
      load_here = load_en && (load_bank == BANK_W'(b));
      if (load_here) begin
        cnt_d[b] = period;
      end else if (cnt_q[b] != '0) begin
        cnt_d[b] = cnt_q[b] - TMR_W'(1);
      end else begin
        cnt_d[b] = cnt_q[b];
      end
      free[b] = (cnt_q[b] <= TMR_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[b] <= '0;
      end else begin
        cnt_q[b] <= cnt_d[b];
      end
    end

    // Timer keeps counting down by one each cycle unless reloaded (R6)
    assert_countdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_here && cnt_q[b] != '0) |=> (cnt_q[b] == $past(cnt_q[b]) - TMR_W'(1)));

    // An idle timer stays idle until a load arrives (R8)
    assert_idle_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_here && cnt_q[b] == '0) |=> (cnt_q[b] == '0));
  end

endmodule

// File: rtl/mps_cs_drive.sv
module mps_cs_drive #(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 show,
  input  logic                 cs_on,
  input  logic [BANK_W-1:0]    bank,
  input  logic [NUM_BANKS-1:0] own_map,
  output logic [NUM_BANKS-1:0] cs_n
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
    always_comb begin
      cs_n[b] = !(show && cs_on && own_map[b] && (bank == BANK_W'(b)));
    end
  end

endmodule

// File: rtl/mem_pattern_seq.sv
module mem_pattern_seq
  import mps_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int DEPTH     = 64,
  parameter int TMR_W     = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [AW-1:0]        req_start,
  input  logic [NUM_BANKS-1:0] own_map,
  input  logic [TMR_W-1:0]     dis_period,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  output logic [NUM_BANKS-1:0] cs_n,
  output logic [CTL_W-1:0]     ctl,
  output logic                 done
);

  seq_state_e          st_q, st_d;
  logic [AW-1:0]       pc_q, pc_d, rd_addr;
  pat_word_t           cur_q, cur_d, rd_word;
  logic [WORD_W-1:0]   rd_raw;
  logic [BANK_W-1:0]   bank_q, bank_d;
  logic                hold_q, hold_d;
  logic [NUM_BANKS-1:0] tmr_free;
  logic                accept, extend, show, tmr_load;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    if (a == AW'(DEPTH - 1)) begin
      return '0;
    end
    return a + AW'(1);
  endfunction

  mps_pattern_ram #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_raw)
  );

  mps_bank_timers #(.NUM_BANKS(NUM_BANKS), .TMR_W(TMR_W)) u_timers (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (tmr_load),
    .load_bank (bank_q),
    .period    (dis_period),
    .free      (tmr_free)
  );

  mps_cs_drive #(.NUM_BANKS(NUM_BANKS)) u_cs (
    .show    (show),
    .cs_on   (cur_q.cs_on),
    .bank    (bank_q),
    .own_map (own_map),
    .cs_n    (cs_n)
  );

  always_comb begin
    rd_addr  = (st_q == ST_IDLE) ? req_start : pc_q;
    rd_word  = pat_word_t'(rd_raw);
    accept   = (st_q == ST_IDLE) && req_valid && tmr_free[req_bank];
    tmr_load = (st_q == ST_RUN) && cur_q.last && cur_q.tmr_on;
    extend   = (st_q == ST_IDLE) && hold_q && req_valid && (req_bank == bank_q);
    show     = (st_q == ST_RUN) || extend;
  end

  always_comb begin
    st_d   = st_q;
    pc_d   = pc_q;
    cur_d  = cur_q;
    bank_d = bank_q;
    hold_d = hold_q;
    unique case (st_q)
      ST_RUN: begin
        if (cur_q.last) begin
          st_d   = ST_IDLE;
          hold_d = cur_q.tmr_on && (dis_period != '0);
        end else begin
          cur_d = rd_word;
          pc_d  = step_addr(pc_q);
        end
      end
      default: begin
        if (accept) begin
          st_d   = ST_RUN;
          cur_d  = rd_word;
          pc_d   = step_addr(req_start);
          bank_d = req_bank;
          hold_d = 1'b0;
        end else if (hold_q && tmr_free[bank_q]) begin
          hold_d = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pc_q   <= '0;
      cur_q  <= '0;
      bank_q <= '0;
      hold_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pc_q   <= pc_d;
      cur_q  <= cur_d;
      bank_q <= bank_d;
      hold_q <= hold_d;
    end
  end

  always_comb begin
    ctl  = show ? cur_q.ctl : '0;
    done = (st_q == ST_RUN) && cur_q.last;
  end

  // done never lasts two cycles (R5)
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // Quiet outputs when idle without a request (R5)
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !req_valid) |-> (cs_n == '1 && !done));

  // At most one chip select low (R3)
  assert_cs_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // Banks not owned are never driven (R4)
  assert_unowned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~cs_n) & ~own_map) == '0);

  // A pattern starts only on a bank whose timer allows it (R10)
  assert_accept_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && st_d == ST_RUN) |-> tmr_free[req_bank]);

endmodule

// File: tb/mem_pattern_seq_tb.sv
`timescale 1ns/1ps
module mem_pattern_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [2:0] req_bank;
  logic [5:0] req_start;
  logic [7:0] own_map;
  logic [7:0] dis_period;
  logic       wr_en;
  logic [5:0] wr_addr;
  logic [6:0] wr_data;
  logic [7:0] cs_n;
  logic [3:0] ctl;
  logic       done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  mem_pattern_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_start(req_start), .own_map(own_map), .dis_period(dis_period),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cs_n(cs_n), .ctl(ctl), .done(done)
  );

  // ---------------- reference model ----------------
  logic [6:0] mram [64];
  logic [6:0] q [$];
  int         tmr [8];
  bit         m_run, m_hold;
  int         m_bank;
  logic [6:0] m_word;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_hold = 0; m_bank = 0; m_word = '0; q.delete();
      for (int b = 0; b < 8; b++) tmr[b] = 0;
    end else begin
      bit load;
      int lb;
      cyc++;
      load = m_run && m_word[0] && m_word[1];
      lb = m_bank;
      if (m_run) begin
        if (m_word[0]) begin
          m_run = 0;
          m_hold = m_word[1] && (dis_period != 0);
        end else begin
          m_word = q.pop_front();
        end
      end else if (req_valid && tmr[req_bank] <= 1) begin
        int a;
        a = req_start;
        q.delete();
        for (int n = 0; n < 64; n++) begin
          q.push_back(mram[a]);
          if (mram[a][0]) break;
          a = (a + 1) % 64;
        end
        m_word = q.pop_front();
        m_run = 1; m_bank = req_bank; m_hold = 0;
      end else if (m_hold && tmr[m_bank] <= 1) begin
        m_hold = 0;
      end
      for (int b = 0; b < 8; b++) begin
        if (load && b == lb) tmr[b] = dis_period;
        else if (tmr[b] > 0) tmr[b] = tmr[b] - 1;
      end
      if (wr_en) mram[wr_addr] = wr_data;
    end
  end

  task automatic check(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic compare();
    bit show;
    logic [7:0] ecs;
    logic [3:0] ectl;
    bit edone;
    show = m_run || (m_hold && req_valid && req_bank == m_bank[2:0]);
    ecs = 8'hFF;
    if (show && m_word[2] && own_map[m_bank]) ecs[m_bank] = 1'b0;
    ectl = show ? m_word[6:3] : 4'h0;
    edone = m_run && m_word[0];
    check({cs_n, ctl, done} == {ecs, ectl, edone}, tag,
          {cs_n, ctl, done}, {ecs, ectl, edone});
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) compare();
  endtask

  task automatic wr(input int a, input logic [6:0] d);
    wr_en = 1; wr_addr = a[5:0]; wr_data = d;
    step();
    wr_en = 0;
  endtask

  function automatic logic [6:0] mk(input int c, input bit cs, input bit t, input bit l);
    return {c[3:0], cs, t, l};
  endfunction

  // present request, return steps until done and cycle of done
  task automatic do_req(input int b, input int s, output int n, output int dcyc);
    req_valid = 1; req_bank = b[2:0]; req_start = s[5:0];
    n = 0; dcyc = 0;
    for (int k = 0; k < 300; k++) begin
      step();
      n++;
      if (done) begin
        dcyc = cyc;
        req_valid = 0;
        return;
      end
    end
    check(0, {tag, " timeout"}, n, 0);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    repeat (n) step();
  endtask

  initial begin
    #1_000_000;
    check(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, d0, d1, d2;
    rst_n = 0; req_valid = 0; req_bank = 0; req_start = 0;
    own_map = 8'hFF; dis_period = 8'd4; wr_en = 0; wr_addr = 0; wr_data = 0;
    repeat (2) @(negedge clk);
    check(cs_n == 8'hFF && ctl == 0 && done == 0, "R1 in reset", {cs_n, ctl, done}, 13'h1FE0);
    rst_n = 1;
    step();
    check(cs_n == 8'hFF && ctl == 0 && done == 0, "R1 after reset", {cs_n, ctl, done}, 13'h1FE0);

    tag = "R2/R3/R5 load";
    wr(0,  mk(1, 1, 0, 0));
    wr(1,  mk(2, 0, 0, 0));
    wr(2,  mk(3, 1, 1, 1));
    wr(10, mk(6, 1, 1, 0));
    wr(11, mk(7, 1, 0, 1));
    wr(20, mk(5, 1, 1, 1));
    wr(62, mk(9, 1, 0, 0));
    wr(63, mk(10, 0, 0, 0));
    idle(2);

    tag = "R2/R3/R5 basic";
    do_req(2, 0, n, d0);
    check(n == 3, "R2 length", n, 3);
    idle(8);

    tag = "R2 wrap";
    do_req(5, 62, n, d0);
    check(n == 5, "R2 wrap length", n, 5);
    idle(8);

    tag = "R6 hold";
    do_req(2, 0, n, d0);
    do_req(2, 20, n, d1);
    check(d1 - d0 == 5, "R6 gap", d1 - d0, 5);
    idle(8);

    tag = "R9 zero period";
    dis_period = 0;
    do_req(2, 0, n, d0);
    do_req(2, 20, n, d1);
    check(d1 - d0 == 2, "R9 gap", d1 - d0, 2);
    dis_period = 4;
    idle(8);

    tag = "R7 mid timer bit";
    do_req(1, 10, n, d0);
    do_req(1, 10, n, d1);
    check(d1 - d0 == 3, "R7 gap", d1 - d0, 3);
    idle(8);

    tag = "R8 other bank";
    do_req(3, 20, n, d0);
    do_req(4, 20, n, d1);
    check(d1 - d0 == 2, "R8 gap", d1 - d0, 2);
    idle(8);

    tag = "R10 earlier bank";
    dis_period = 10;
    do_req(3, 20, n, d0);
    do_req(4, 20, n, d1);
    do_req(3, 20, n, d2);
    check(d1 - d0 == 2, "R8 gap long", d1 - d0, 2);
    check(d2 - d1 == 9, "R10 gap", d2 - d1, 9);
    dis_period = 4;
    idle(14);

    tag = "R4 not owned";
    own_map = 8'hFB;
    do_req(2, 0, n, d0);
    check(n == 3, "R4 length", n, 3);
    idle(3);
    own_map = 8'hFF;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule